// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block keeps wall-clock time as a count of elapsed seconds for a chip domain that stays powered while the rest of the chip sleeps. It holds two 32-bit counters, one counting up and one counting down. A once-per-second qualifier, `tick_en`, advances both counters together, so software that loads them as a complementary pair finds that their sum stays at all-ones. Two compare channels watch the up count. Each channel latches an event bit, which can raise an interrupt, drive a wake output, or both.

Software reaches the block through a plain single-cycle 32-bit register port. Its registers are:

- a configuration register, which holds the interrupt enables, the wake enables, a forced-wake bit, a counter halt and a self-clearing counter reset;
- a write-1-to-clear event register;
- a setup tag register. Boot code writes a fixed signature there once, so that a later boot can see the block is already configured. While the tag holds that signature, `inited_o` is high.

Top module: `sec_alarm_rtc`

## Requirements
- R1: After reset the registers read as follows: up count 0, down count 0xFFFFFFFF, both compare values 0xFFFFFFFF, configuration 0, events 0 and tag 0. The outputs `irq_o`, `wake_o` and `inited_o` are all low.
- R2: The word registers sit at these byte addresses: up count 0x00, down count 0x04, compare 0 at 0x08, compare 1 at 0x0C, configuration 0x10, events 0x14, tag 0x18. Address 0x1C reads 0.
- R2 (configuration fields): the configuration register reads back only bits 0,1,2,3,4,6,7. All other bits read 0.
- R3: In a clock cycle where `tick_en` is high and configuration bit 6 (halt) is low, the up count increments by one and the down count decrements by one. Both wrap modulo 2^32.
- R4: While halt is set, `tick_en` has no effect on either counter, and bus writes to either counter still load the written value.
- R5: Event bit 0 (channel 0) or bit 1 (channel 1) is set on the clock edge after the up count equals that channel's compare value. The bit stays set after the count moves on, and it sets again on every cycle that the equality holds.
- R6: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. If the bit is being set and cleared in the same cycle, the set wins.
- R7: `irq_o` is high when event bit 0 is set with configuration bit 0 set, or when event bit 1 is set with configuration bit 1 set.
- R8: `wake_o` is high when event bit 0 is set with configuration bit 2 set, when event bit 1 is set with configuration bit 3 set, or when configuration bit 7 is set. Event bit 2 is set on the edge after a channel is equal while that channel's wake enable (bit 2 or bit 3) is set.
- R9: Writing configuration bit 4 loads 0 into the up count and 0xFFFFFFFF into the down count on that write edge. Bit 4 then returns to 0 one cycle later without any further write.
- R10: `inited_o` is high exactly while the tag register holds 0xB5C13F27.
- R11: A bus write to a counter, made in a cycle where a tick would otherwise advance it, loads the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-second advance qualifier, sampled on `clk` |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Alarm interrupt request |
| wake_o | output | 1 | Wake request to the power controller |
| inited_o | output | 1 | Setup tag holds the signature |

## Verification
The assertions take `tick_en` and the bus strobes to be synchronous to `clk` and stable around its rising edge. They also take each bus write to last exactly one cycle. The complementary-sum property is not asserted, because it depends on software loading matched values. The bench changes every input on the falling edge and loads counters only while halt is set, except in the one scenario that targets write-over-tick precedence. The bench also never sets the self-clearing reset bit when it wants to read configuration back in the next cycle.

// File: rtl/sec_alarm_pkg.sv
package sec_alarm_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_CMP  = 2;
  localparam int unsigned NUM_EVT  = NUM_CMP + 1;
  localparam logic [31:0] TAG_SIG  = 32'hB5C1_3F27;

  // word slot indices (byte address >> 2); software relies on these
  typedef enum logic [2:0] {
    SLOT_UP   = 3'd0,
    SLOT_DN   = 3'd1,
    SLOT_CMP0 = 3'd2,
    SLOT_CMP1 = 3'd3,
    SLOT_CFG  = 3'd4,
    SLOT_EVT  = 3'd5,
    SLOT_TAG  = 3'd6,
    SLOT_NONE = 3'd7
  } slot_e;

  // configuration bit positions
  localparam int unsigned CFG_IRQ0  = 0;
  localparam int unsigned CFG_IRQ1  = 1;
  localparam int unsigned CFG_WAKE0 = 2;
  localparam int unsigned CFG_WAKE1 = 3;
  localparam int unsigned CFG_SRST  = 4;
  localparam int unsigned CFG_HALT  = 6;
  localparam int unsigned CFG_FORCE = 7;

  // event bit positions
  localparam int unsigned EVT_WAKE  = 2;

endpackage

// File: rtl/sar_rst_sync.sv
module sar_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sar_counters.sv
module sar_counters #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         halt,
  input  logic         clr,
  input  logic         ld_up,
  input  logic         ld_dn,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] up_q,
  output logic [W-1:0] dn_q
);

  localparam logic [W-1:0] UP_INIT = '0;
  localparam logic [W-1:0] DN_INIT = '1;
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

  logic         adv;
  logic         up_ce, dn_ce;
  logic [W-1:0] up_d, dn_d;

  assign adv = tick_en & ~halt;

  always_comb begin
    up_ce = clr | ld_up | adv;
    dn_ce = clr | ld_dn | adv;
    if (clr) begin
      up_d = UP_INIT;
      dn_d = DN_INIT;
    end else begin
      up_d = ld_up ? wdata : up_q + ONE;
      dn_d = ld_dn ? wdata : dn_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= UP_INIT;
      dn_q <= DN_INIT;
    end else begin
      if (up_ce) up_q <= up_d;
      if (dn_ce) dn_q <= dn_d;
    end
  end

endmodule

// File: rtl/sar_match_chan.sv
module sar_match_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] up_cnt,
  output logic [W-1:0] cmp_q,
  output logic         hit
);

  localparam logic [W-1:0] CMP_INIT = '1;

  logic [W-1:0] cmp_d;

  always_comb begin
    cmp_d = ld ? wdata : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cmp_q <= CMP_INIT;
    else if (ld) cmp_q <= cmp_d;
  end

  assign hit = (up_cnt == cmp_q);

endmodule

// File: rtl/sar_events.sv
module sar_events #(
  parameter int unsigned NC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] hit,
  input  logic [NC-1:0] irq_en,
  input  logic [NC-1:0] wake_en,
  input  logic          force_wake,
  input  logic          clr_en,
  input  logic [NC:0]   clr_mask,
  output logic [NC:0]   evt_q,
  output logic          irq_o,
  output logic          wake_o
);

  logic [NC:0] set_v;
  logic [NC:0] clr_v;
  logic [NC:0] evt_d;

  always_comb begin
    set_v[NC-1:0] = hit;
    set_v[NC]     = |(hit & wake_en);
    clr_v         = clr_en ? clr_mask : '0;
    // a set arriving in the same cycle as a clear is kept
    evt_d         = set_v | (evt_q & ~clr_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign irq_o  = |(evt_q[NC-1:0] & irq_en);
  assign wake_o = (|(evt_q[NC-1:0] & wake_en)) | force_wake;

endmodule

// File: rtl/sec_alarm_rtc.sv
module sec_alarm_rtc
  import sec_alarm_pkg::*;
#(
  parameter int unsigned W      = DATA_W,
  parameter int unsigned ADDR_W = 5,
  parameter logic [W-1:0] TAG   = TAG_SIG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o,
  output logic              wake_o,
  output logic              inited_o
);

  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned NSLOT  = 1 << IDX_W;
  localparam int unsigned NC     = NUM_CMP;

  logic rst_q_n;

  sar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  // ---------------- decode ----------------
  logic [IDX_W-1:0] idx;
  logic [NSLOT-1:0] wr_stb;
  logic             unused_addr;

  assign idx         = bus_addr[ADDR_W-1:2];
  assign unused_addr = ^bus_addr[1:0];

  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    assign wr_stb[s] = bus_sel & bus_wr & (idx == IDX_W'(s));
  end

  // ---------------- configuration ----------------
  logic [NC-1:0] cfg_irq_en_q, cfg_irq_en_d;
  logic [NC-1:0] cfg_wake_en_q, cfg_wake_en_d;
  logic          cfg_halt_q, cfg_halt_d;
  logic          cfg_force_q, cfg_force_d;
  logic          cfg_srst_q, cfg_srst_d;
  logic          wr_cfg;
  logic          srst_pulse;

  assign wr_cfg     = wr_stb[SLOT_CFG];
  assign srst_pulse = wr_cfg & bus_wdata[CFG_SRST];

  always_comb begin
    cfg_irq_en_d  = cfg_irq_en_q;
    cfg_wake_en_d = cfg_wake_en_q;
    cfg_halt_d    = cfg_halt_q;
    cfg_force_d   = cfg_force_q;
    cfg_srst_d    = srst_pulse;
    if (wr_cfg) begin
      cfg_irq_en_d  = {bus_wdata[CFG_IRQ1], bus_wdata[CFG_IRQ0]};
      cfg_wake_en_d = {bus_wdata[CFG_WAKE1], bus_wdata[CFG_WAKE0]};
      cfg_halt_d    = bus_wdata[CFG_HALT];
      cfg_force_d   = bus_wdata[CFG_FORCE];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_irq_en_q  <= '0;
      cfg_wake_en_q <= '0;
      cfg_halt_q    <= 1'b0;
      cfg_force_q   <= 1'b0;
      cfg_srst_q    <= 1'b0;
    end else begin
      cfg_srst_q <= cfg_srst_d;
      if (wr_cfg) begin
        cfg_irq_en_q  <= cfg_irq_en_d;
        cfg_wake_en_q <= cfg_wake_en_d;
        cfg_halt_q    <= cfg_halt_d;
        cfg_force_q   <= cfg_force_d;
      end
    end
  end

  // ---------------- counters ----------------
  logic [W-1:0] up_q, dn_q;

  sar_counters #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .tick_en (tick_en),
    .halt    (cfg_halt_q),
    .clr     (srst_pulse),
    .ld_up   (wr_stb[SLOT_UP]),
    .ld_dn   (wr_stb[SLOT_DN]),
    .wdata   (bus_wdata),
    .up_q    (up_q),
    .dn_q    (dn_q)
  );

  // ---------------- compare channels ----------------
  logic [NC-1:0][W-1:0] cmp_q;
  logic [NC-1:0]        hit;

  for (genvar c = 0; c < NC; c++) begin : g_cmp
    sar_match_chan #(.W(W)) u_chan (
      .clk    (clk),
      .rst_n  (rst_q_n),
      .ld     (wr_stb[SLOT_CMP0 + c]),
      .wdata  (bus_wdata),
      .up_cnt (up_q),
      .cmp_q  (cmp_q[c]),
      .hit    (hit[c])
    );
  end

  // ---------------- events ----------------
  logic [NC:0] evt_q;
  logic        evt_clr;

  assign evt_clr = wr_stb[SLOT_EVT];

  sar_events #(.NC(NC)) u_evt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .hit        (hit),
    .irq_en     (cfg_irq_en_q),
    .wake_en    (cfg_wake_en_q),
    .force_wake (cfg_force_q),
    .clr_en     (evt_clr),
    .clr_mask   (bus_wdata[NC:0]),
    .evt_q      (evt_q),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  // ---------------- setup tag ----------------
  logic [W-1:0] tag_q, tag_d;
  logic         wr_tag;

  assign wr_tag = wr_stb[SLOT_TAG];

  always_comb begin
    tag_d = wr_tag ? bus_wdata : tag_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    tag_q <= '0;
    else if (wr_tag) tag_q <= tag_d;
  end

  assign inited_o = (tag_q == TAG);

  // ---------------- read mux ----------------
  logic [W-1:0] cfg_rd;

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CFG_IRQ0]  = cfg_irq_en_q[0];
    cfg_rd[CFG_IRQ1]  = cfg_irq_en_q[1];
    cfg_rd[CFG_WAKE0] = cfg_wake_en_q[0];
    cfg_rd[CFG_WAKE1] = cfg_wake_en_q[1];
    cfg_rd[CFG_SRST]  = cfg_srst_q;
    cfg_rd[CFG_HALT]  = cfg_halt_q;
    cfg_rd[CFG_FORCE] = cfg_force_q;
  end

  always_comb begin
    unique case (slot_e'(idx))
      SLOT_UP:   bus_rdata = up_q;
      SLOT_DN:   bus_rdata = dn_q;
      SLOT_CMP0: bus_rdata = cmp_q[0];
      SLOT_CMP1: bus_rdata = cmp_q[1];
      SLOT_CFG:  bus_rdata = cfg_rd;
      SLOT_EVT:  bus_rdata = W'(evt_q);
      SLOT_TAG:  bus_rdata = tag_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sec_alarm_rtc_chk.sv
module sec_alarm_rtc_chk #(
  parameter int unsigned W   = 32,
  parameter logic [W-1:0] TAG = 32'hB5C1_3F27
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick_en,
  input logic         halt,
  input logic         srst_pulse,
  input logic         srst_bit,
  input logic         ld_up,
  input logic [W-1:0] wdata,
  input logic         wr_tag,
  input logic [W-1:0] up,
  input logic [W-1:0] dn,
  input logic [1:0]   hit,
  input logic [1:0]   irq_en,
  input logic         force_wake,
  input logic         evt_clr,
  input logic [2:0]   evt,
  input logic         irq_o,
  input logic         wake_o,
  input logic         inited_o
);

  // R3
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !halt && !ld_up && !srst_pulse) |=> (up == $past(up) + 1'b1));

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ld_up && !srst_pulse) |=> (up == $past(up)));

  // R5
  match_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> evt[0]);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[1] && evt_clr && wdata[1]) |=> evt[1]);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && irq_en[0]) |-> irq_o);

  // R8
  force_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_wake |-> wake_o);

  // R9
  srst_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> (up == '0 && dn == '1 && srst_bit));

  // R9
  srst_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_bit && !srst_pulse) |=> !srst_bit);

  // R10
  tag_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tag && wdata == TAG) |=> inited_o);

endmodule

bind sec_alarm_rtc sec_alarm_rtc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .tick_en    (tick_en),
  .halt       (cfg_halt_q),
  .srst_pulse (srst_pulse),
  .srst_bit   (cfg_srst_q),
  .ld_up      (wr_stb[0]),
  .wdata      (bus_wdata),
  .wr_tag     (wr_tag),
  .up         (up_q),
  .dn         (dn_q),
  .hit        (hit),
  .irq_en     (cfg_irq_en_q),
  .force_wake (cfg_force_q),
  .evt_clr    (evt_clr),
  .evt        (evt_q),
  .irq_o      (irq_o),
  .wake_o     (wake_o),
  .inited_o   (inited_o)
);

// File: tb/sec_alarm_rtc_bench.sv
module sec_alarm_rtc_bench;

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        wake_o;
  logic        inited_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [4:0] A_UP = 5'h00, A_DN = 5'h04, A_C0 = 5'h08, A_C1 = 5'h0C,
                         A_CFG = 5'h10, A_EVT = 5'h14, A_TAG = 5'h18, A_HOLE = 5'h1C;

  sec_alarm_rtc u_sec_alarm_rtc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o), .inited_o(inited_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_UP, v);   check("R1 up", v, 32'h0);
    rd(A_DN, v);   check("R1 dn", v, 32'hFFFF_FFFF);
    rd(A_C0, v);   check("R1 cmp0", v, 32'hFFFF_FFFF);
    rd(A_C1, v);   check("R1 cmp1", v, 32'hFFFF_FFFF);
    rd(A_CFG, v);  check("R1 cfg", v, 32'h0);
    rd(A_EVT, v);  check("R1 evt", v, 32'h0);
    rd(A_TAG, v);  check("R1 tag", v, 32'h0);
    check("R1 outs", {29'b0, irq_o, wake_o, inited_o}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_C1, 32'h1234_5678);
    rd(A_C1, v);   check("R2 cmp1 rw", v, 32'h1234_5678);
    wr(A_CFG, 32'hFFFF_FFCF);
    rd(A_CFG, v);  check("R2 cfg fields", v, 32'h0000_00CF);
    check("R8 force wake", {31'b0, wake_o}, 32'h1);
    wr(A_HOLE, 32'hDEAD_BEEF);
    rd(A_HOLE, v); check("R2 hole", v, 32'h0);
    wr(A_CFG, 32'h40);
    wr(A_C1, 32'hFFFF_FFFF);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(A_CFG, 32'h40);
    wr(A_UP, 32'd5); wr(A_DN, ~32'd5);
    wr(A_CFG, 32'h0);
    ticks(10);
    rd(A_UP, v); check("R3 up +10", v, 32'd15);
    rd(A_DN, v); check("R3 dn -10", v, ~32'd15);
    wr(A_CFG, 32'h40);
    wr(A_UP, 32'hFFFF_FFFE); wr(A_DN, 32'h1);
    wr(A_CFG, 32'h0);
    ticks(3);
    rd(A_UP, v); check("R3 up wrap", v, 32'h1);
    rd(A_DN, v); check("R3 dn wrap", v, 32'hFFFF_FFFE);
  endtask

  task automatic t_halt();
    logic [31:0] v;
    wr(A_CFG, 32'h40);
    wr(A_UP, 32'd77);
    ticks(5);
    rd(A_UP, v); check("R4 halt hold", v, 32'd77);
    wr(A_CFG, 32'h0);
    @(negedge clk);
    tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_UP; bus_wdata = 32'd100;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(A_UP, v); check("R11 write over tick", v, 32'd100);
  endtask

  task automatic t_match();
    logic [31:0] v;
    wr(A_CFG, 32'h40);
    wr(A_UP, 32'd0);
    wr(A_C0, 32'd3);
    wr(A_EVT, 32'h7);
    wr(A_CFG, 32'h01);
    ticks(3);
    @(negedge clk);
    rd(A_EVT, v); check("R5 ch0 event", v, 32'h1);
    check("R7 irq ch0", {31'b0, irq_o}, 32'h1);
    ticks(1);
    rd(A_EVT, v); check("R5 latched", v, 32'h1);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R6 w1c", v, 32'h0);
    check("R7 irq low", {31'b0, irq_o}, 32'h0);
    wr(A_C1, 32'd4);
    @(negedge clk);
    rd(A_EVT, v); check("R5 ch1 event", v, 32'h2);
    check("R7 ch1 gated off", {31'b0, irq_o}, 32'h0);
    wr(A_CFG, 32'h02);
    check("R7 irq ch1", {31'b0, irq_o}, 32'h1);
    wr(A_C1, 32'hFFFF_FFFF);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    wr(A_CFG, 32'h40);
    wr(A_EVT, 32'h7);
    wr(A_UP, 32'd3);
    wr(A_C0, 32'd3);
    @(negedge clk);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R6 set wins", v, 32'h1);
    wr(A_C0, 32'hFFFF_FFFF);
    wr(A_EVT, 32'h1);
    rd(A_EVT, v); check("R5 retrigger stopped", v, 32'h0);
  endtask

  task automatic t_wake();
    logic [31:0] v;
    wr(A_CFG, 32'h48);
    wr(A_EVT, 32'h7);
    check("R8 wake idle", {31'b0, wake_o}, 32'h0);
    wr(A_UP, 32'd50);
    wr(A_C1, 32'd50);
    @(negedge clk);
    rd(A_EVT, v); check("R8 wake event", v, 32'h6);
    check("R8 wake ch1", {31'b0, wake_o}, 32'h1);
    wr(A_CFG, 32'h40);
    check("R8 wake disabled", {31'b0, wake_o}, 32'h0);
    wr(A_C1, 32'hFFFF_FFFF);
    wr(A_EVT, 32'h7);
  endtask

  task automatic t_srst();
    logic [31:0] v;
    wr(A_CFG, 32'h40);
    wr(A_UP, 32'd1000); wr(A_DN, 32'd1234);
    wr(A_CFG, 32'h10);
    @(negedge clk);
    rd(A_UP, v);  check("R9 up cleared", v, 32'h0);
    rd(A_DN, v);  check("R9 dn reloaded", v, 32'hFFFF_FFFF);
    rd(A_CFG, v); check("R9 self clear", v, 32'h0);
  endtask

  task automatic t_tag();
    logic [31:0] v;
    wr(A_TAG, 32'h0000_1234);
    rd(A_TAG, v); check("R10 tag rw", v, 32'h0000_1234);
    check("R10 not inited", {31'b0, inited_o}, 32'h0);
    wr(A_TAG, 32'hB5C1_3F27);
    check("R10 inited", {31'b0, inited_o}, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_halt();
    t_match();
    t_setwins();
    t_wake();
    t_srst();
    t_tag();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got=%h exp=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule